// File: doc/BRIEF.md
# Load/Store Address Generator

This block turns one single-transfer load or store instruction word into the memory address and the new base-register value. It takes the instruction, the base register contents, the offset register contents and the current carry flag. A one-cycle `start` strobe captures them. One clock later it presents the address, the value to write back into the base register, an enable for that write, a flag that asks for the access to run with user privilege, and a flag that marks an encoding it does not accept. A `done` pulse marks that result.

Two offset families are decoded. The word/byte family carries either a 12-bit unsigned immediate or a register offset that passes through a barrel shifter, with the usual zero-amount special cases. The halfword/signed family carries either an 8-bit immediate split across two nibbles of the instruction or a plain register offset. In both families the indexing bits choose:

- pre-indexing or post-indexing,
- adding or subtracting the offset,
- whether the base is updated.

The unprivileged-access form is defined only as a post-indexed word/byte transfer.

Top module: `lsag_top`

## Requirements
- R1: While `rst` is high and after it falls, until the first `start`, the outputs `addr`, `wb_value`, `wb_en`, `user_access`, `illegal` and `done` are all 0.
- R2: `done` is high for exactly the one cycle after a cycle with `start` high. Every other output changes only in that cycle and holds its value while `start` stays low.
- R3: A word/byte instruction has insn[27:26] = 01. With insn[25] = 0 its offset is insn[11:0], zero-extended.
- R4: insn[23] = 1 makes the indexed value base + offset. insn[23] = 0 makes it base − offset, modulo 2^32.
- R5: With insn[24] = 1 (pre-index), `addr` is the indexed value. `wb_en` equals insn[21]. `wb_value` is the indexed value when `wb_en` is 1 and the unchanged base when it is 0.
- R6: With insn[24] = 0 (post-index), `addr` is the unchanged base, `wb_en` is 1 and `wb_value` is the indexed value.
- R7: A word/byte instruction with insn[25] = 1 uses `ofs_val` shifted by insn[11:7]. The shift type comes from insn[6:5]: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right.
- R8: With a shift amount of 0, logical left passes `ofs_val` through unchanged. Logical right gives 0. Arithmetic right gives 32 copies of ofs_val[31]. Rotate right gives {carry_in, ofs_val[31:1]}.
- R9: A halfword/signed instruction has insn[27:25] = 000, insn[7] = 1, insn[4] = 1 and insn[6:5] ≠ 00. With insn[22] = 1 its offset is {insn[11:8], insn[3:0]}, zero-extended. With insn[22] = 0 its offset is `ofs_val` unshifted.
- R10: `user_access` is 1 exactly for a word/byte instruction with insn[24] = 0 and insn[21] = 1. That instruction is post-indexed as in R6.
- R11: Any other encoding sets `illegal` to 1 and sets `addr`, `wb_value`, `wb_en` and `user_access` to 0. This includes a halfword/signed instruction with insn[24] = 0 and insn[21] = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture strobe for the inputs below |
| insn | input | 32 | Instruction word |
| base_val | input | 32 | Base register contents |
| ofs_val | input | 32 | Offset register contents |
| carry_in | input | 1 | Current carry flag |
| addr | output | 32 | Memory address |
| wb_value | output | 32 | Value for the base register |
| wb_en | output | 1 | Base register write enable |
| user_access | output | 1 | Perform the access with user privilege |
| illegal | output | 1 | Encoding not accepted |
| done | output | 1 | Result valid pulse |

## Verification
The shifted-register offset is swept over all four shift types and all 32 amounts. It uses operands with the top bit set, with the top bit clear, and with the low bit set, under both carry values. This separates the zero-amount special cases from ordinary shifts, and arithmetic right shifts from logical ones. The immediate forms are swept over every combination of the pre, up and writeback bits with extreme and mixed immediates. Every split-nibble value is tried, which exposes swapped or misplaced nibbles. Rejected encodings and idle cycles show that the outputs stay quiet and stable.

// File: rtl/lsag_pkg.sv
package lsag_pkg;

    localparam int INSN_W = 32;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shift_e;

    typedef enum logic [1:0] {
        FMT_WORD = 2'b00,
        FMT_HALF = 2'b01,
        FMT_BAD  = 2'b10
    } fmt_e;

    typedef struct packed {
        fmt_e        fmt;
        logic        pre;
        logic        up;
        logic        wbit;
        logic        reg_ofs;
        logic        unpriv;
        shift_e      sh;
        logic [4:0]  amt;
        logic [11:0] imm12;
        logic [7:0]  split_imm;
    } dec_t;

    // Field extraction and format classification of one transfer word.
    function automatic dec_t decode_insn(input logic [INSN_W-1:0] w);
        dec_t d;
        d.pre       = w[24];
        d.up        = w[23];
        d.wbit      = w[21];
        d.sh        = shift_e'(w[6:5]);
        d.amt       = w[11:7];
        d.imm12     = w[11:0];
        d.split_imm = {w[11:8], w[3:0]};
        if (w[27:26] == 2'b01) begin
            d.fmt     = FMT_WORD;
            d.reg_ofs = w[25];
            d.unpriv  = !w[24] && w[21];
        end else if (w[27:25] == 3'b000 && w[7] && w[4] &&
                     w[6:5] != 2'b00 && !(!w[24] && w[21])) begin
            d.fmt     = FMT_HALF;
            d.reg_ofs = !w[22];
            d.unpriv  = 1'b0;
        end else begin
            d.fmt     = FMT_BAD;
            d.reg_ofs = 1'b0;
            d.unpriv  = 1'b0;
        end
        return d;
    endfunction

endpackage

// File: rtl/lsag_decode.sv
module lsag_decode
    import lsag_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec
);
    always_comb dec = decode_insn(insn);
endmodule

// File: rtl/lsag_offset.sv
module lsag_offset
    import lsag_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  dec_t            dec,
    input  logic [XLEN-1:0] ofs_val,
    input  logic            carry_in,
    output logic [XLEN-1:0] offset
);
    localparam int IMM_W   = 12;
    localparam int SPLIT_W = 8;

    logic [XLEN-1:0] shifted;
    logic [XLEN-1:0] imm_word;
    logic [XLEN-1:0] imm_half;
    int unsigned     rot_back;

    generate
        if (XLEN > IMM_W) begin : g_pad
            assign imm_word = {{(XLEN-IMM_W){1'b0}}, dec.imm12};
            assign imm_half = {{(XLEN-SPLIT_W){1'b0}}, dec.split_imm};
        end else begin : g_trunc
            assign imm_word = dec.imm12[XLEN-1:0];
            assign imm_half = {{(XLEN-SPLIT_W){1'b0}}, dec.split_imm};
        end
    endgenerate

    assign rot_back = XLEN - 32'(dec.amt);

    always_comb begin
        unique case (dec.sh)
            SH_LSL: shifted = ofs_val << dec.amt;
            SH_LSR: shifted = (dec.amt == '0) ? '0 : (ofs_val >> dec.amt);
            SH_ASR: shifted = (dec.amt == '0) ? {XLEN{ofs_val[XLEN-1]}}
                                              : XLEN'($signed(ofs_val) >>> dec.amt);
            SH_ROR: shifted = (dec.amt == '0) ? {carry_in, ofs_val[XLEN-1:1]}
                                              : ((ofs_val >> dec.amt) | (ofs_val << rot_back));
            default: shifted = ofs_val;
        endcase
    end

    always_comb begin
        if (dec.fmt == FMT_WORD)
            offset = dec.reg_ofs ? shifted : imm_word;
        else if (dec.fmt == FMT_HALF)
            offset = dec.reg_ofs ? ofs_val : imm_half;
        else
            offset = '0;
    end
endmodule

// File: rtl/lsag_index.sv
module lsag_index #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] base_val,
    input  logic [XLEN-1:0] offset,
    input  logic            pre,
    input  logic            up,
    input  logic            wbit,
    output logic [XLEN-1:0] addr,
    output logic [XLEN-1:0] wb_value,
    output logic            wb_en
);
    logic [XLEN-1:0] moved;

    always_comb begin
        moved    = up ? (base_val + offset) : (base_val - offset);
        addr     = pre ? moved : base_val;
        wb_en    = pre ? wbit : 1'b1;
        wb_value = wb_en ? moved : base_val;
    end
endmodule

// File: rtl/lsag_top.sv
module lsag_top
    import lsag_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [INSN_W-1:0] insn,
    input  logic [XLEN-1:0]   base_val,
    input  logic [XLEN-1:0]   ofs_val,
    input  logic              carry_in,
    output logic [XLEN-1:0]   addr,
    output logic [XLEN-1:0]   wb_value,
    output logic              wb_en,
    output logic              user_access,
    output logic              illegal,
    output logic              done
);
    dec_t            dec;
    logic [XLEN-1:0] offset;
    logic [XLEN-1:0] addr_c;
    logic [XLEN-1:0] wbv_c;
    logic            wben_c;

    lsag_decode u_dec (
        .insn (insn),
        .dec  (dec)
    );

    lsag_offset #(.XLEN(XLEN)) u_ofs (
        .dec      (dec),
        .ofs_val  (ofs_val),
        .carry_in (carry_in),
        .offset   (offset)
    );

    lsag_index #(.XLEN(XLEN)) u_idx (
        .base_val (base_val),
        .offset   (offset),
        .pre      (dec.pre),
        .up       (dec.up),
        .wbit     (dec.wbit),
        .addr     (addr_c),
        .wb_value (wbv_c),
        .wb_en    (wben_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr        <= '0;
            wb_value    <= '0;
            wb_en       <= 1'b0;
            user_access <= 1'b0;
            illegal     <= 1'b0;
            done        <= 1'b0;
        end else begin
            done <= start;
            if (start) begin
                if (dec.fmt == FMT_BAD) begin
                    addr        <= '0;
                    wb_value    <= '0;
                    wb_en       <= 1'b0;
                    user_access <= 1'b0;
                    illegal     <= 1'b1;
                end else begin
                    addr        <= addr_c;
                    wb_value    <= wbv_c;
                    wb_en       <= wben_c;
                    user_access <= dec.unpriv;
                    illegal     <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/lsag_checker.sv
module lsag_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic [XLEN-1:0] base_val,
    input logic [XLEN-1:0] addr,
    input logic [XLEN-1:0] wb_value,
    input logic            wb_en,
    input logic            user_access,
    input logic            illegal,
    input logic            done
);
    assert_done_after_start_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> done);

    assert_done_only_after_start_R2: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done);

    assert_outputs_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(addr) && $stable(wb_value) && $stable(wb_en)
                    && $stable(user_access) && $stable(illegal)));

    assert_illegal_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!wb_en && !user_access && addr == '0 && wb_value == '0));

    assert_unpriv_post_index_R10: assert property (@(posedge clk) disable iff (rst)
        (done && user_access) |-> (wb_en && addr == $past(base_val)));

    assert_no_wb_keeps_base_R5: assert property (@(posedge clk) disable iff (rst)
        (done && !wb_en && !illegal) |-> (wb_value == $past(base_val)));
endmodule

bind lsag_top lsag_checker #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .base_val    (base_val),
    .addr        (addr),
    .wb_value    (wb_value),
    .wb_en       (wb_en),
    .user_access (user_access),
    .illegal     (illegal),
    .done        (done)
);

// File: tb/lsag_top_test.sv
module lsag_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] insn = '0;
    logic [31:0] base_val = '0;
    logic [31:0] ofs_val = '0;
    logic        carry_in = 1'b0;
    logic [31:0] addr, wb_value;
    logic        wb_en, user_access, illegal, done;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    lsag_top uut (
        .clk(clk), .rst(rst), .start(start), .insn(insn), .base_val(base_val),
        .ofs_val(ofs_val), .carry_in(carry_in), .addr(addr), .wb_value(wb_value),
        .wb_en(wb_en), .user_access(user_access), .illegal(illegal), .done(done)
    );

    always #5 clk = ~clk;

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Independent reference model written from the requirements.
    task automatic model(input logic [31:0] w, input logic [31:0] b, input logic [31:0] o,
                         input logic c, output logic [31:0] ea, output logic [31:0] ev,
                         output logic ee, output logic eu, output logic ei);
        logic [31:0] off, moved;
        logic [63:0] dbl;
        int amt;
        logic word_f, half_f;
        amt    = int'(w[11:7]);
        word_f = (w[27:26] == 2'b01);
        half_f = (w[27:25] == 3'b000) && w[7] && w[4] && (w[6:5] != 2'b00)
                 && !(w[24] == 1'b0 && w[21] == 1'b1);
        ea = 0; ev = 0; ee = 0; eu = 0; ei = 0;
        off = 0;
        if (!word_f && !half_f) begin
            ei = 1;
        end else begin
            if (word_f && !w[25]) off = {20'd0, w[11:0]};                    // R3
            else if (word_f) begin                                          // R7 R8
                case (w[6:5])
                    2'b00: off = o << amt;
                    2'b01: off = (amt == 0) ? 32'd0 : o >> amt;
                    2'b10: off = (amt == 0) ? (o[31] ? 32'hFFFF_FFFF : 32'd0)
                                            : 32'($signed(o) >>> amt);
                    default: begin
                        dbl = {o, o};
                        off = (amt == 0) ? {c, o[31:1]} : dbl[amt +: 32];
                    end
                endcase
            end else if (w[22]) off = {24'd0, w[11:8], w[3:0]};             // R9
            else off = o;
            moved = w[23] ? b + off : b - off;                              // R4
            if (w[24]) begin                                                // R5
                ea = moved; ee = w[21]; ev = w[21] ? moved : b;
            end else begin                                                  // R6
                ea = b; ee = 1; ev = moved;
            end
            eu = word_f && !w[24] && w[21];                                 // R10
        end
    endtask

    task automatic run(input logic [31:0] w, input logic [31:0] b, input logic [31:0] o,
                       input logic c, input string tag);
        logic [31:0] ea, ev;
        logic ee, eu, ei;
        model(w, b, o, c, ea, ev, ee, eu, ei);
        @(negedge clk);
        insn = w; base_val = b; ofs_val = o; carry_in = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        insn = ~w; base_val = ~b; ofs_val = ~o;
        total++;
        if (addr !== ea || wb_value !== ev || wb_en !== ee || user_access !== eu
            || illegal !== ei || done !== 1'b1) begin
            bad++;
            $display("FAIL %s insn=%h: actual addr=%h wbv=%h wbe=%b ua=%b ill=%b done=%b expected addr=%h wbv=%h wbe=%b ua=%b ill=%b done=1",
                     tag, w, addr, wb_value, wb_en, user_access, illegal, done,
                     ea, ev, ee, eu, ei);
        end
        @(negedge clk);
        total++;
        if (done !== 1'b0 || addr !== ea || wb_value !== ev || wb_en !== ee) begin   // R2
            bad++;
            $display("FAIL R2 hold insn=%h: actual done=%b addr=%h wbv=%h expected done=0 addr=%h wbv=%h",
                     w, done, addr, wb_value, ea, ev);
        end
    endtask

    function automatic logic [31:0] word_insn(logic p, logic u, logic wb, logic regf,
                                              logic [11:0] low);
        return {4'hE, 2'b01, regf, p, u, 1'b0, wb, 1'b1, 4'h3, 4'h4, low};
    endfunction

    function automatic logic [31:0] half_insn(logic p, logic u, logic immf, logic wb,
                                              logic [7:0] imm);
        return {4'hE, 3'b000, p, u, immf, wb, 1'b1, 4'h3, 4'h4, imm[7:4], 4'b1011, imm[3:0]};
    endfunction

    initial begin
        logic [31:0] ofs_set [3];
        ofs_set[0] = 32'h8000_0001;
        ofs_set[1] = 32'h1234_5678;
        ofs_set[2] = 32'hF0F0_0F0E;

        repeat (3) @(negedge clk);
        total++;
        if (addr !== 0 || wb_value !== 0 || wb_en || user_access || illegal || done) begin
            bad++;
            $display("FAIL R1 reset: actual addr=%h wbv=%h wbe=%b ua=%b ill=%b done=%b expected all 0",
                     addr, wb_value, wb_en, user_access, illegal, done);
        end
        rst = 1'b0;
        repeat (2) @(negedge clk);
        total++;
        if (addr !== 0 || done !== 0 || wb_en !== 0) begin
            bad++;
            $display("FAIL R1 idle after reset: actual addr=%h done=%b wbe=%b expected 0",
                     addr, done, wb_en);
        end

        // R3 R4 R5 R6 R10: immediate word/byte across all index bit combinations
        for (int k = 0; k < 8; k++) begin
            for (int j = 0; j < 3; j++) begin
                logic [11:0] im;
                im = (j == 0) ? 12'h000 : (j == 1) ? 12'hFFF : 12'h5A3;
                run(word_insn(k[2], k[1], k[0], 1'b0, im), 32'h0000_0800 + 32'(k),
                    32'hDEAD_BEEF, 1'b0, "R3_R4_R5_R6_R10 word imm");
                run(word_insn(k[2], k[1], k[0], 1'b0, im), 32'h0000_0002,
                    32'h0, 1'b1, "R4 wrap word imm");
            end
        end

        // R7 R8: every shift type and amount
        for (int s = 0; s < 4; s++) begin
            for (int a = 0; a < 32; a++) begin
                for (int v = 0; v < 3; v++) begin
                    for (int c = 0; c < 2; c++) begin
                        logic [11:0] low;
                        low = {a[4:0], s[1:0], 1'b0, 4'h5};
                        run(word_insn(v[0], c[0], a[0], 1'b1, low), 32'h4000_1000,
                            ofs_set[v], c[0], (a == 0) ? "R8 zero amount" : "R7 shifted reg");
                    end
                end
            end
        end

        // R9: every split immediate value, plus register form
        for (int i = 0; i < 256; i++)
            run(half_insn(1'b1, i[0], 1'b1, i[1], 8'(i)), 32'h0001_0000, 32'hFFFF_FFFF,
                1'b0, "R9 split imm");
        for (int k = 0; k < 8; k++) begin
            if (!(k[2] == 1'b0 && k[0] == 1'b1))
                run(half_insn(k[2], k[1], 1'b0, k[0], 8'hA5), 32'h7FFF_FFF0,
                    32'h0000_0123, 1'b1, "R9_R5_R6 half reg");
        end

        // R11: rejected encodings
        run(half_insn(1'b0, 1'b1, 1'b1, 1'b1, 8'h12), 32'h100, 32'h4, 1'b0, "R11 half unpriv");
        run(half_insn(1'b0, 1'b0, 1'b0, 1'b1, 8'h00), 32'h100, 32'h4, 1'b0, "R11 half unpriv reg");
        run({4'hE, 2'b11, 26'h0123456}, 32'h100, 32'h4, 1'b0, "R11 class 11");
        run({4'hE, 2'b10, 26'h0123456}, 32'h100, 32'h4, 1'b0, "R11 class 10");
        run({4'hE, 3'b000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'h34, 4'h1, 4'b1001, 4'h2},
            32'h100, 32'h4, 1'b0, "R11 half sh00");
        run({4'hE, 3'b000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'h34, 4'h1, 4'b0011, 4'h2},
            32'h100, 32'h4, 1'b0, "R11 half bit7 clear");

        // R2: long idle keeps outputs and done low
        run(word_insn(1'b0, 1'b1, 1'b1, 1'b0, 12'h010), 32'h2000, 32'h0, 1'b0, "R10 unpriv");
        repeat (5) @(negedge clk);
        total++;
        if (done !== 0 || addr !== 32'h2000 || wb_value !== 32'h2010 || user_access !== 1) begin
            bad++;
            $display("FAIL R2 idle hold: actual done=%b addr=%h wbv=%h ua=%b expected done=0 addr=00002000 wbv=00002010 ua=1",
                     done, addr, wb_value, user_access);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule